// File: doc/BRIEF.md
# User-Level Alert Delivery Controller

This block sits between a cache-line watch tracker and the processor core. The tracker reports an alert when something happens to a watched line. Each alert carries the line address and a cause code. The block decides whether the alert is taken and how it is handed to software. Software first registers a handler address, which arms delivery. When an alert is taken in user mode, the block sends a one-cycle fetch redirect to the handler. This acts as a subroutine call forced by hardware. When an alert is taken in kernel mode, the block raises an interrupt request instead, and that request stays high until the core acknowledges it.

Taking an alert records the interrupted program counter, the line address and the cause code in capture registers, so the handler can read them. The block then masks itself. Later alerts are not delivered until software issues an unmask command. If an alert arrives while the block is masked, a sticky lost-alert flag is set, so the handler knows that information may be missing. A clear-handler command disarms delivery and sends a release-all pulse to the tracker, so that every watched line is dropped.

Top module: `alert_dispatch`

## Requirements
- R1: After reset the following are all low: redirect, interrupt request, armed, masked, lost flag and release-all.
- R2: A set-handler command loads the handler address. Both handler_o and armed_o reflect it on the next cycle. A set-handler command issued while already armed replaces the address.
- R3: An alert is taken when it arrives while the block is armed and unmasked and no clear-handler command is present. If the core is in user mode (kernel_i low), redir_vld_o is high for exactly one cycle, on the cycle after the alert. During that cycle redir_pc_o equals the handler address, and no interrupt is raised.
- R4: An alert taken in kernel mode (kernel_i high) raises irq_o on the next cycle and does not redirect. irq_o stays high until irq_ack_i is seen, and drops on the cycle after the acknowledge.
- R5: On the cycle after a taken alert, the capture registers hold values from the alert cycle: saved_pc_o holds cur_pc_i, desc_line_o holds alert_line_i, and desc_cause_o holds alert_cause_i. The cause encoding is 0 for a remote write, 1 for a local write, 2 for an eviction, and 3 is reserved. The field is passed through as given.
- R6: A taken alert sets masked_o on the next cycle. While masked, alerts produce no redirect and no interrupt, and they leave the capture registers unchanged. An unmask command clears masked_o on the next cycle.
- R7: An alert that arrives while armed and masked sets lost_o on the next cycle. lost_o stays set until an unmask command clears it. If a masked alert and an unmask command arrive in the same cycle, lost_o ends up set.
- R8: A clear-handler command has these effects on the next cycle: armed_o, masked_o and lost_o all go low, and release_all_o is high for exactly one cycle. An alert that arrives in the same cycle as the command is discarded.
- R9: While the block is not armed, alerts are discarded. They produce no redirect, no interrupt, no capture update and no change to lost_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_hdl_i | input | 1 | Register the handler and arm delivery |
| hdl_addr_i | input | ADDR_W | Handler address for set_hdl_i |
| clr_hdl_i | input | 1 | Disarm delivery and release all watched lines |
| unmask_i | input | 1 | Re-enable delivery and clear the lost flag |
| cur_pc_i | input | ADDR_W | Current program counter |
| kernel_i | input | 1 | Core is in kernel mode |
| alert_vld_i | input | 1 | Alert event from the tracker |
| alert_line_i | input | LINE_W | Line address of the alert |
| alert_cause_i | input | CAUSE_W | Cause code of the alert |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| redir_vld_o | output | 1 | One-cycle fetch redirect pulse |
| redir_pc_o | output | ADDR_W | Redirect target |
| irq_o | output | 1 | Alert interrupt request |
| handler_o | output | ADDR_W | Registered handler address |
| armed_o | output | 1 | Delivery enabled |
| masked_o | output | 1 | Further alerts masked |
| lost_o | output | 1 | Alerts arrived while masked |
| saved_pc_o | output | ADDR_W | PC captured when the alert was taken |
| desc_line_o | output | LINE_W | Captured line address |
| desc_cause_o | output | CAUSE_W | Captured cause |
| release_all_o | output | 1 | One-cycle release-all pulse to the tracker |

## Verification
Every result is registered exactly once. The redirect, the interrupt request, the capture registers, the mask, the lost flag, the armed state and the release-all pulse therefore all change on the first clock edge after the command or alert that causes them. The bench drives each stimulus on a falling edge and holds it for one full cycle. It samples on the following falling edge, which is where each result is due. It samples once more a cycle later to confirm that the pulses have ended and that held state has stayed. Same-cycle pairings (masked alert with unmask, alert with clear-handler) are applied in a single cycle, and their outcome is checked on the next falling edge.

// File: rtl/alert_pkg.sv
package alert_pkg;
  typedef enum logic [1:0] {
    CAUSE_REMOTE_WR = 2'd0,
    CAUSE_LOCAL_WR  = 2'd1,
    CAUSE_EVICT     = 2'd2,
    CAUSE_RSVD      = 2'd3
  } cause_e;

  typedef enum logic {
    ROUTE_REDIRECT = 1'b0,
    ROUTE_IRQ      = 1'b1
  } route_e;

  function automatic route_e pick_route(input logic kernel);
    return kernel ? ROUTE_IRQ : ROUTE_REDIRECT;
  endfunction
endpackage

// File: rtl/alert_hdl_reg.sv
module alert_hdl_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] handler_o,
  output logic              armed_o,
  output logic              release_o
);
  logic [ADDR_W-1:0] hdl_q, hdl_d;
  logic              arm_q, arm_d;
  logic              rel_q, rel_d;
  logic              hdl_en;

  always_comb begin
    hdl_en = set_i && !clr_i;
    hdl_d  = addr_i;
    arm_d  = arm_q;
    if (clr_i)      arm_d = 1'b0;
    else if (set_i) arm_d = 1'b1;
    rel_d  = clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdl_q <= '0;
      arm_q <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      if (hdl_en) hdl_q <= hdl_d;
      arm_q <= arm_d;
      rel_q <= rel_d;
    end
  end

  assign handler_o = hdl_q;
  assign armed_o   = arm_q;
  assign release_o = rel_q;
endmodule

// File: rtl/alert_gate.sv
module alert_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic alert_i,
  input  logic armed_i,
  input  logic clr_i,
  input  logic unmask_i,
  output logic take_o,
  output logic masked_o,
  output logic lost_o
);
  logic mask_q, mask_d;
  logic lost_q, lost_d;
  logic live;

  always_comb begin
    live   = alert_i && armed_i && !clr_i;
    take_o = live && !mask_q;
    if (clr_i) begin
      mask_d = 1'b0;
      lost_d = 1'b0;
    end else begin
      mask_d = take_o || (mask_q && !unmask_i);
      lost_d = (live && mask_q) || (lost_q && !unmask_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      lost_q <= lost_d;
    end
  end

  assign masked_o = mask_q;
  assign lost_o   = lost_q;
endmodule

// File: rtl/alert_capture.sv
module alert_capture #(
  parameter int ADDR_W  = 16,
  parameter int LINE_W  = 12,
  parameter int CAUSE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [LINE_W-1:0]  line_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int REC_W = ADDR_W + LINE_W + CAUSE_W;
  logic [REC_W-1:0] rec_q, rec_d;

  always_comb rec_d = {pc_i, line_i, cause_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= '0;
    else if (take_i) rec_q <= rec_d;
  end

  assign pc_o    = rec_q[REC_W-1 -: ADDR_W];
  assign line_o  = rec_q[CAUSE_W +: LINE_W];
  assign cause_o = rec_q[CAUSE_W-1:0];
endmodule

// File: rtl/alert_route.sv
module alert_route
  import alert_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              kernel_i,
  input  logic [ADDR_W-1:0] handler_i,
  input  logic              ack_i,
  output logic              redir_vld_o,
  output logic [ADDR_W-1:0] redir_pc_o,
  output logic              irq_o
);
  route_e            way;
  logic              rv_q, rv_d;
  logic [ADDR_W-1:0] rpc_q;
  logic              irq_q, irq_d;
  logic              rpc_en;

  always_comb begin
    way    = pick_route(kernel_i);
    rv_d   = take_i && (way == ROUTE_REDIRECT);
    rpc_en = rv_d;
    irq_d  = (take_i && (way == ROUTE_IRQ)) || (irq_q && !ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      rpc_q <= '0;
      irq_q <= 1'b0;
    end else begin
      rv_q  <= rv_d;
      irq_q <= irq_d;
      if (rpc_en) rpc_q <= handler_i;
    end
  end

  assign redir_vld_o = rv_q;
  assign redir_pc_o  = rpc_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/alert_dispatch.sv
module alert_dispatch #(
  parameter int ADDR_W  = 16,
  parameter int LINE_W  = 12,
  parameter int CAUSE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_hdl_i,
  input  logic [ADDR_W-1:0]  hdl_addr_i,
  input  logic               clr_hdl_i,
  input  logic               unmask_i,
  input  logic [ADDR_W-1:0]  cur_pc_i,
  input  logic               kernel_i,
  input  logic               alert_vld_i,
  input  logic [LINE_W-1:0]  alert_line_i,
  input  logic [CAUSE_W-1:0] alert_cause_i,
  input  logic               irq_ack_i,
  output logic               redir_vld_o,
  output logic [ADDR_W-1:0]  redir_pc_o,
  output logic               irq_o,
  output logic [ADDR_W-1:0]  handler_o,
  output logic               armed_o,
  output logic               masked_o,
  output logic               lost_o,
  output logic [ADDR_W-1:0]  saved_pc_o,
  output logic [LINE_W-1:0]  desc_line_o,
  output logic [CAUSE_W-1:0] desc_cause_o,
  output logic               release_all_o
);
  logic take;

  alert_hdl_reg #(.ADDR_W(ADDR_W)) u_hdl (
    .clk(clk), .rst_n(rst_n), .set_i(set_hdl_i), .clr_i(clr_hdl_i),
    .addr_i(hdl_addr_i), .handler_o(handler_o), .armed_o(armed_o),
    .release_o(release_all_o)
  );

  alert_gate u_gate (
    .clk(clk), .rst_n(rst_n), .alert_i(alert_vld_i), .armed_i(armed_o),
    .clr_i(clr_hdl_i), .unmask_i(unmask_i), .take_o(take),
    .masked_o(masked_o), .lost_o(lost_o)
  );

  alert_capture #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .CAUSE_W(CAUSE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .take_i(take), .pc_i(cur_pc_i),
    .line_i(alert_line_i), .cause_i(alert_cause_i), .pc_o(saved_pc_o),
    .line_o(desc_line_o), .cause_o(desc_cause_o)
  );

  alert_route #(.ADDR_W(ADDR_W)) u_route (
    .clk(clk), .rst_n(rst_n), .take_i(take), .kernel_i(kernel_i),
    .handler_i(handler_o), .ack_i(irq_ack_i), .redir_vld_o(redir_vld_o),
    .redir_pc_o(redir_pc_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/alert_dispatch_chk.sv
module alert_dispatch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_hdl_i,
  input logic              unmask_i,
  input logic              set_hdl_i,
  input logic              alert_vld_i,
  input logic              irq_ack_i,
  input logic              redir_vld_o,
  input logic [ADDR_W-1:0] redir_pc_o,
  input logic [ADDR_W-1:0] handler_o,
  input logic              irq_o,
  input logic              armed_o,
  input logic              masked_o,
  input logic              lost_o,
  input logic              release_all_o
);
  AST_REDIR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_o |=> !redir_vld_o); // R3
  AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_vld_o && !$past(set_hdl_i)) |-> redir_pc_o == handler_o); // R3
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_ack_i) |=> irq_o); // R4
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_ack_i) |=> !irq_o); // R4
  AST_MASK_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_o |-> masked_o); // R6
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && !unmask_i && !clr_hdl_i) |=> lost_o); // R7
  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hdl_i |=> (release_all_o && !armed_o && !masked_o && !lost_o)); // R8
  AST_UNARMED_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && !lost_o) |=> !lost_o); // R9
endmodule

bind alert_dispatch alert_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_hdl_i(clr_hdl_i), .unmask_i(unmask_i),
  .set_hdl_i(set_hdl_i), .alert_vld_i(alert_vld_i), .irq_ack_i(irq_ack_i),
  .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o), .handler_o(handler_o),
  .irq_o(irq_o), .armed_o(armed_o), .masked_o(masked_o), .lost_o(lost_o),
  .release_all_o(release_all_o)
);

// File: tb/alert_dispatch_bench.sv
module alert_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 12;
  localparam int CW = 2;

  logic clk, rst_n;
  logic set_hdl, clr_hdl, unmask, kernel, alert_vld, irq_ack;
  logic [AW-1:0] hdl_addr, cur_pc;
  logic [LW-1:0] a_line;
  logic [CW-1:0] a_cause;
  logic redir_vld, irq, armed, masked, lost, rel_all;
  logic [AW-1:0] redir_pc, handler, saved_pc;
  logic [LW-1:0] d_line;
  logic [CW-1:0] d_cause;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  alert_dispatch #(.ADDR_W(AW), .LINE_W(LW), .CAUSE_W(CW)) u_alert_dispatch (
    .clk(clk), .rst_n(rst_n), .set_hdl_i(set_hdl), .hdl_addr_i(hdl_addr),
    .clr_hdl_i(clr_hdl), .unmask_i(unmask), .cur_pc_i(cur_pc), .kernel_i(kernel),
    .alert_vld_i(alert_vld), .alert_line_i(a_line), .alert_cause_i(a_cause),
    .irq_ack_i(irq_ack), .redir_vld_o(redir_vld), .redir_pc_o(redir_pc),
    .irq_o(irq), .handler_o(handler), .armed_o(armed), .masked_o(masked),
    .lost_o(lost), .saved_pc_o(saved_pc), .desc_line_o(d_line),
    .desc_cause_o(d_cause), .release_all_o(rel_all)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    set_hdl = 0; clr_hdl = 0; unmask = 0; alert_vld = 0; irq_ack = 0;
  endtask

  // inputs applied now (at a falling edge), held across one rising edge
  task automatic tick();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_alert(input logic k, input logic [AW-1:0] pc,
                          input logic [LW-1:0] ln, input logic [CW-1:0] cs);
    alert_vld = 1; kernel = k; cur_pc = pc; a_line = ln; a_cause = cs;
    tick();
  endtask

  initial begin
    rst_n = 0; kernel = 0; cur_pc = '0; hdl_addr = '0; a_line = '0; a_cause = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "redir", redir_vld, 0);
    check("R1", "irq", irq, 0);
    check("R1", "armed", armed, 0);
    check("R1", "masked", masked, 0);
    check("R1", "lost", lost, 0);
    check("R1", "release", rel_all, 0);

    // R9 unarmed alert discarded
    do_alert(0, 16'h0badd, 12'h055, 2'd2);
    check("R9", "redir", redir_vld, 0);
    check("R9", "irq", irq, 0);
    check("R9", "lost", lost, 0);
    check("R9", "saved_pc", saved_pc, 0);
    check("R9", "masked", masked, 0);

    // R2 arm
    set_hdl = 1; hdl_addr = 16'h4000; tick();
    check("R2", "handler", handler, 16'h4000);
    check("R2", "armed", armed, 1);
    set_hdl = 1; hdl_addr = 16'h4800; tick();
    check("R2", "handler reload", handler, 16'h4800);

    // sweep: mode x cause x pc
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 4; c++) begin
        for (int p = 0; p < 4; p++) begin
          logic [AW-1:0] pc = AW'(16'h1000 + 37*p + 301*c + 4099*k);
          logic [LW-1:0] ln = LW'(c*16 + p*3 + k*512);
          do_alert(k[0], pc, ln, c[CW-1:0]);
          check(k ? "R4" : "R3", "redir", redir_vld, k ? 0 : 1);
          check(k ? "R4" : "R3", "irq", irq, k ? 1 : 0);
          if (!k) check("R3", "redir_pc", redir_pc, 16'h4800);
          check("R5", "saved_pc", saved_pc, pc);
          check("R5", "line", d_line, ln);
          check("R5", "cause", d_cause, c);
          check("R6", "masked", masked, 1);
          tick();
          check("R3", "redir ends", redir_vld, 0);
          if (k) begin
            check("R4", "irq held", irq, 1);
            irq_ack = 1; tick();
            check("R4", "irq dropped", irq, 0);
          end
          unmask = 1; tick();
          check("R6", "unmasked", masked, 0);
        end
      end
    end

    // R6 masked alerts ignored, R7 lost set
    do_alert(0, 16'h2222, 12'h111, 2'd1);
    check("R3", "redir", redir_vld, 1);
    do_alert(0, 16'h3333, 12'h222, 2'd2);
    check("R6", "no redir masked", redir_vld, 0);
    check("R6", "pc kept", saved_pc, 16'h2222);
    check("R6", "line kept", d_line, 12'h111);
    check("R7", "lost set", lost, 1);
    do_alert(1, 16'h3344, 12'h223, 2'd0);
    check("R6", "no irq masked", irq, 0);
    tick(); tick();
    check("R7", "lost sticky", lost, 1);
    // masked alert with unmask in the same cycle: lost stays set
    unmask = 1; do_alert(0, 16'h5555, 12'h333, 2'd3);
    check("R7", "lost set wins", lost, 1);
    check("R6", "unmask next cycle", masked, 0);
    check("R6", "no redir", redir_vld, 0);
    unmask = 1; tick();
    check("R7", "lost cleared", lost, 0);

    // R8 clear with simultaneous alert
    do_alert(0, 16'h6666, 12'h444, 2'd0);
    check("R3", "redir", redir_vld, 1);
    clr_hdl = 1; do_alert(0, 16'h7777, 12'h555, 2'd1);
    check("R8", "release", rel_all, 1);
    check("R8", "armed", armed, 0);
    check("R8", "masked", masked, 0);
    check("R8", "redir", redir_vld, 0);
    check("R8", "pc kept", saved_pc, 16'h6666);
    tick();
    check("R8", "release pulse ends", rel_all, 0);
    // unarmed alert after clear
    do_alert(1, 16'h8888, 12'h666, 2'd2);
    check("R9", "irq", irq, 0);
    check("R9", "lost", lost, 0);
    check("R9", "pc kept", saved_pc, 16'h6666);
    // clear while armed and unmasked with pending alert: discarded
    set_hdl = 1; hdl_addr = 16'h9000; tick();
    clr_hdl = 1; do_alert(0, 16'h9999, 12'h777, 2'd0);
    check("R8", "alert discarded", redir_vld, 0);
    tick();
    check("R8", "no late redir", redir_vld, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule